// File: doc/BRIEF.md
# Register-Run Word Store Sequencer

This block stores a contiguous run of general-purpose registers into consecutive 32-bit memory words. A single start request supplies the first register number, a base value, a flag that replaces the base by zero, and a signed 16-bit displacement. The block then walks from that register up to the highest register, 31. For each register it reads the value through a register-file read port and issues one word write carrying the low 32 bits. Each new write goes to the address four bytes above the previous one.

The memory side is a valid/ready write port. The block holds a pending write, unchanged, for as long as ready stays low. It raises a one-cycle done pulse once the write for register 31 has been accepted, and then becomes idle. The register file is read combinationally: the value for `rf_raddr_o` is expected on `rf_rdata_i` in the same cycle. The block changes no other architectural state.

Top module: `regrun_store_seq`

## Requirements
- R1: The address of the first write is the sign-extended 16-bit `disp_i` added to `base_i`, or to zero when `base_zero_i` is 1. The sum wraps modulo 2^64.
- R2: The cycle after an accepted start, `busy_o` is 1 and `rf_raddr_o` equals the requested start register. Registers are then visited in ascending order.
- R3: Each write carries bits 31:0 of the 64-bit value returned for the register currently addressed.
- R4: After each accepted write (`mem_valid_o` and `mem_ready_i` both 1 at a clock edge), the register number rises by 1 and the address rises by 4, wrapping modulo 2^64.
- R5: A run issues exactly 32 minus the start register writes. A start of 31 gives one write, and a start of 0 gives 32 writes.
- R6: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the next cycle keeps `mem_valid_o` at 1, with the address, register number and write data unchanged.
- R7: `done_o` is 1 for exactly the one cycle that follows acceptance of the register-31 write. In that cycle `busy_o` and `mem_valid_o` are 0.
- R8: A start request made while `busy_o` is 1 is ignored. The run in progress continues with the same registers and addresses.
- R9: During reset, and after reset until a start arrives, `busy_o`, `done_o` and `mem_valid_o` are 0. A reset during a run abandons that run.
- R10: `mem_valid_o` is 1 only while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| start_reg_i | input | 5 | First register number of the run |
| base_i | input | 64 | Base value for the address |
| base_zero_i | input | 1 | 1: use zero in place of the base |
| disp_i | input | 16 | Signed byte displacement |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the last write is accepted |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 64 | Register value for `rf_raddr_o`, same cycle |
| mem_valid_o | output | 1 | Write request pending |
| mem_ready_i | input | 1 | Memory accepts the pending write |
| mem_addr_o | output | 64 | Byte address of the write |
| mem_wdata_o | output | 32 | Word to be written |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are: holding steady under back-pressure, a step of one register and four bytes per acceptance, launch at the requested register and computed address, the done pulse after the final acceptance, and valid only while busy. Other properties need whole scenarios from the bench, because they concern a full run rather than one cycle. These are the exact number of writes for a given start, the correct low-word data, address wrap-around, immunity to starts made mid-run, and recovery from a reset during a run.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [0:0] {
        SRS_IDLE = 1'b0,
        SRS_EMIT = 1'b1
    } srs_state_e;

endpackage

// File: rtl/srs_ea_gen.sv
module srs_ea_gen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_zero_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        base_eff = base_zero_i ? '0 : base_i;
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        ea_o     = base_eff + disp_ext;
    end
endmodule

// File: rtl/srs_word_pick.sv
module srs_word_pick #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic [XLEN-1:0]   reg_val_i,
    output logic [WORD_W-1:0] word_o
);
    generate
        if (XLEN == WORD_W) begin : g_same
            assign word_o = reg_val_i;
        end else begin : g_low
            assign word_o = reg_val_i[WORD_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int IDX_W    = 5,
    parameter int LAST_IDX = 31,
    parameter int STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  start_idx_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [IDX_W-1:0]  LAST_V = IDX_W'(LAST_IDX);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    typedef struct packed {
        srs_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            SRS_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = SRS_EMIT;
                    ctl_d.idx  = start_idx_i;
                    ctl_d.addr = start_addr_i;
                end
            end
            SRS_EMIT: begin
                if (mem_ready_i) begin
                    if (ctl_q.idx == LAST_V) begin
                        ctl_d.st   = SRS_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.idx  = ctl_q.idx + 1'b1;
                        ctl_d.addr = ctl_q.addr + STEP_V;
                    end
                end
            end
            default: ctl_d.st = SRS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: SRS_IDLE, idx: '0, addr: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.st == SRS_EMIT);
    assign done_o = ctl_q.done;
    assign idx_o  = ctl_q.idx;
    assign addr_o = ctl_q.addr;
endmodule

// File: rtl/regrun_store_seq.sv
module regrun_store_seq #(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int DISP_W = 16,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [$clog2(NREG)-1:0] start_reg_i,
    input  logic [XLEN-1:0]         base_i,
    input  logic                    base_zero_i,
    input  logic [DISP_W-1:0]       disp_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [$clog2(NREG)-1:0] rf_raddr_o,
    input  logic [XLEN-1:0]         rf_rdata_i,
    output logic                    mem_valid_o,
    input  logic                    mem_ready_i,
    output logic [XLEN-1:0]         mem_addr_o,
    output logic [WORD_W-1:0]       mem_wdata_o
);
    localparam int IDX_W    = $clog2(NREG);
    localparam int LAST_IDX = NREG - 1;
    localparam int STEP     = WORD_W / 8;

    logic [XLEN-1:0] ea_w;
    logic            busy_w;

    srs_ea_gen #(
        .ADDR_W (XLEN),
        .DISP_W (DISP_W)
    ) ea_i (
        .base_i      (base_i),
        .base_zero_i (base_zero_i),
        .disp_i      (disp_i),
        .ea_o        (ea_w)
    );

    srs_ctrl #(
        .ADDR_W   (XLEN),
        .IDX_W    (IDX_W),
        .LAST_IDX (LAST_IDX),
        .STEP     (STEP)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_idx_i  (start_reg_i),
        .start_addr_i (ea_w),
        .mem_ready_i  (mem_ready_i),
        .busy_o       (busy_w),
        .done_o       (done_o),
        .idx_o        (rf_raddr_o),
        .addr_o       (mem_addr_o)
    );

    srs_word_pick #(
        .XLEN   (XLEN),
        .WORD_W (WORD_W)
    ) pick_i (
        .reg_val_i (rf_rdata_i),
        .word_o    (mem_wdata_o)
    );

    assign busy_o      = busy_w;
    assign mem_valid_o = busy_w;
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int DISP_W = 16,
    parameter int WORD_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [$clog2(NREG)-1:0] start_reg_i,
    input logic [XLEN-1:0]         base_i,
    input logic                    base_zero_i,
    input logic [DISP_W-1:0]       disp_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic [$clog2(NREG)-1:0] rf_raddr_o,
    input logic                    mem_valid_o,
    input logic                    mem_ready_i,
    input logic [XLEN-1:0]         mem_addr_o
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] LAST_V = IDX_W'(NREG - 1);
    localparam logic [XLEN-1:0]  STEP_V = XLEN'(WORD_W / 8);

    logic [XLEN-1:0] launch_addr;
    assign launch_addr = (base_zero_i ? '0 : base_i)
                       + {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};

    // R2
    launch_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && rf_raddr_o == $past(start_reg_i));

    // R1
    launch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> mem_addr_o == $past(launch_addr));

    // R4
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && rf_raddr_o != LAST_V |=>
        mem_valid_o && rf_raddr_o == $past(rf_raddr_o) + 1'b1
        && mem_addr_o == $past(mem_addr_o) + STEP_V);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=>
        mem_valid_o && $stable(mem_addr_o) && $stable(rf_raddr_o));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && rf_raddr_o == LAST_V |=>
        done_o && !busy_o && !mem_valid_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_valid_o);
endmodule

bind regrun_store_seq srs_chk #(
    .XLEN   (XLEN),
    .NREG   (NREG),
    .DISP_W (DISP_W),
    .WORD_W (WORD_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_reg_i (start_reg_i),
    .base_i      (base_i),
    .base_zero_i (base_zero_i),
    .disp_i      (disp_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rf_raddr_o  (rf_raddr_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/regrun_store_seq_tb_top.sv
`timescale 1ns/1ps
module regrun_store_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  start_reg_i = '0;
    logic [63:0] base_i = '0;
    logic        base_zero_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic        busy_o, done_o, mem_valid_o;
    logic [4:0]  rf_raddr_o;
    logic [63:0] rf_rdata_i;
    logic        mem_ready_i = 1'b0;
    logic [63:0] mem_addr_o;
    logic [31:0] mem_wdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    regrun_store_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_reg_i(start_reg_i),
        .base_i(base_i), .base_zero_i(base_zero_i), .disp_i(disp_i),
        .busy_o(busy_o), .done_o(done_o), .rf_raddr_o(rf_raddr_o),
        .rf_rdata_i(rf_rdata_i), .mem_valid_o(mem_valid_o),
        .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    function automatic logic [63:0] reg_model(input logic [4:0] r);
        reg_model = {32'hC0DE_0000 | {27'd0, r},
                     32'h1000_0000 + {27'd0, r} * 32'h0101_0007};
    endfunction

    always_comb rf_rdata_i = reg_model(rf_raddr_o);

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0]  sreg;
        logic [63:0] base;
        logic        zero;
        logic [15:0] disp;
        logic [1:0]  mode;
        logic        inject;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{5'd31, 64'h0000_0000_0000_1000, 1'b0, 16'h0010, 2'd0, 1'b0},
        '{5'd0,  64'h0000_0000_2000_0000, 1'b0, 16'h0040, 2'd1, 1'b1},
        '{5'd10, 64'hDEAD_BEEF_0000_0000, 1'b1, 16'hFFF0, 2'd2, 1'b1},
        '{5'd28, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 16'h0004, 2'd0, 1'b0},
        '{5'd5,  64'h0000_0000_0001_0000, 1'b0, 16'h8000, 2'd3, 1'b1},
        '{5'd30, 64'h0000_0000_0000_0100, 1'b1, 16'h7FFC, 2'd3, 1'b0},
        '{5'd20, 64'h1234_5678_9ABC_DEF0, 1'b0, 16'h0000, 2'd1, 1'b0}
    };

    function automatic logic ready_pat(input logic [1:0] mode, input int cyc);
        case (mode)
            2'd0:    ready_pat = 1'b1;
            2'd1:    ready_pat = cyc[0];
            2'd2:    ready_pat = (cyc % 3) != 2;
            default: ready_pat = (cyc % 5) == 4;
        endcase
    endfunction

    // Runs one store sequence and checks R1-style launch, data, stepping, stalls and done.
    task automatic run_op(input vec_t v);
        logic [63:0] exp_addr;
        logic [4:0]  exp_idx;
        int          writes;
        bit          last_acc, stalled, fin;
        logic [63:0] st_addr;
        logic [31:0] st_data;
        logic [4:0]  st_idx;
        exp_addr = (v.zero ? 64'd0 : v.base) + {{48{v.disp[15]}}, v.disp};
        exp_idx  = v.sreg;
        writes   = 0;
        last_acc = 1'b0;
        stalled  = 1'b0;
        fin      = 1'b0;
        st_addr  = '0;
        st_data  = '0;
        st_idx   = '0;
        @(negedge clk);
        start_i     = 1'b1;
        start_reg_i = v.sreg;
        base_i      = v.base;
        base_zero_i = v.zero;
        disp_i      = v.disp;
        mem_ready_i = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            mem_ready_i = ready_pat(v.mode, cyc);
            if (v.inject && cyc == 3) begin
                start_i     = 1'b1;
                start_reg_i = 5'd7;
                base_i      = 64'h5555_0000;
                disp_i      = 16'h0100;
            end else begin
                start_i = 1'b0;
                base_i  = ~v.base;
            end
            #1;
            if (cyc == 0) begin
                check(busy_o && rf_raddr_o == v.sreg, "R2 launch register",
                      {59'd0, rf_raddr_o}, {59'd0, v.sreg});
                check(mem_addr_o == exp_addr, "R1 launch address", mem_addr_o, exp_addr);
            end
            if (last_acc) begin
                check(done_o && !busy_o && !mem_valid_o, "R7 done after last write",
                      {61'd0, done_o, busy_o, mem_valid_o}, 64'd4);
                fin = 1'b1;
                break;
            end
            if (done_o)
                check(1'b0, "R7 early done", 64'd1, 64'd0);
            if (stalled)
                check(mem_valid_o && mem_addr_o == st_addr && rf_raddr_o == st_idx
                      && mem_wdata_o == st_data, "R6 stall hold", mem_addr_o, st_addr);
            stalled = 1'b0;
            if (mem_valid_o && mem_ready_i) begin
                check(rf_raddr_o == exp_idx, v.inject ? "R8 R4 register step" : "R4 register step",
                      {59'd0, rf_raddr_o}, {59'd0, exp_idx});
                check(mem_addr_o == exp_addr, "R4 address step", mem_addr_o, exp_addr);
                check(mem_wdata_o == reg_model(exp_idx)[31:0], "R3 low word data",
                      {32'd0, mem_wdata_o}, {32'd0, reg_model(exp_idx)[31:0]});
                writes++;
                if (exp_idx == 5'd31) last_acc = 1'b1;
                exp_idx  = exp_idx + 5'd1;
                exp_addr = exp_addr + 64'd4;
            end else if (mem_valid_o) begin
                stalled = 1'b1;
                st_addr = mem_addr_o;
                st_data = mem_wdata_o;
                st_idx  = rf_raddr_o;
            end
        end
        if (!fin) check(1'b0, "R7 run did not finish", 64'd0, 64'd1);
        check(writes == 32 - int'(v.sreg), v.inject ? "R8 R5 write count" : "R5 write count",
              64'(writes), 64'(32 - int'(v.sreg)));
        mem_ready_i = 1'b0;
        @(negedge clk);
        #1;
        check(!done_o && !busy_o, "R7 single pulse", {62'd0, done_o, busy_o}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !done_o && !mem_valid_o, "R9 in reset",
              {61'd0, busy_o, done_o, mem_valid_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!busy_o && !done_o && !mem_valid_o, "R9 after reset R10",
              {61'd0, busy_o, done_o, mem_valid_o}, 64'd0);

        for (int i = 0; i < NVEC; i++) run_op(VECS[i]);

        // R9: reset during a run abandons it
        @(negedge clk);
        start_i = 1'b1; start_reg_i = 5'd0; base_zero_i = 1'b1; disp_i = 16'h0020;
        @(negedge clk);
        start_i = 1'b0; mem_ready_i = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!busy_o && !mem_valid_o && !done_o, "R9 reset mid-run",
              {61'd0, busy_o, done_o, mem_valid_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; mem_ready_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(!busy_o && !mem_valid_o && !done_o, "R9 idle after mid-run reset",
              {61'd0, busy_o, done_o, mem_valid_o}, 64'd0);
        run_op(VECS[3]);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule